// File: doc/BRIEF.md
# Sobel Edge Closing Overlay

This block is the edge-marking stage of a streaming video pipeline. It receives a filtered 8-bit grayscale stream together with the red, green and blue streams of the same image. It finds edges in the grayscale image with a 3x3 Sobel operator and a fixed magnitude threshold. It cleans the binary edge map with a morphological closing, which is a dilation followed by an erosion over a small cross-shaped neighbourhood. Wherever the cleaned map is set, it paints a fixed magenta colour onto the RGB pixel of the same coordinate.

Pixels arrive one per clock in raster order. `in_vld` qualifies each pixel, `in_sof` marks the first pixel of a frame and `in_eol` marks the last pixel of each line. The frame size is fixed by parameters. The block has three windowed stages in a row. Each stage holds two lines plus three pixels of history in a shift-register line buffer, and carries the RGB triple forward so that the triple stays aligned with the centre of that stage's window. The `in_eol` of the last row closes a frame. After that pixel the block drains its remaining rows by itself, with no further input.

Top module: `edge_close_overlay`

## Requirements
- R1: During reset and after it, `out_vld`, `out_sof` and `out_eol` are low until processed pixels emerge.
- R2: The gradient at pixel (y,x) is |Gx|+|Gy|, computed at full precision. Gx is the right column of the 3x3 window minus the left column, and Gy is the bottom row minus the top row, both weighted 1,2,1 with the centre line doubled.
- R3: A pixel is an edge only when its magnitude is strictly greater than EDGE_THR (default 12). A magnitude of exactly 12 gives no edge.
- R4: The Sobel, dilation and erosion windows all use replicate padding. A neighbour outside the frame takes the value of the nearest pixel on the border.
- R5: The edge map is closed by first dilating with the cross made of the centre and its four orthogonal neighbours (OR), then eroding the result with the same cross (AND).
- R6: Where the closed bit is 1, each output channel is the input channel plus the edge colour (255,0,255), saturated at 255. Red and blue therefore become 255 and green is unchanged. Where the bit is 0, the RGB values pass through unchanged.
- R7: The colour overlaid at output coordinate (y,x) is applied to the RGB input that arrived with the grayscale pixel at (y,x).
- R8: Each frame produces exactly IMG_W*IMG_H output pixels in raster order. `out_sof` is set on the first of them and `out_eol` on every pixel in column IMG_W-1. Neither marker is ever set while `out_vld` is low.
- R9: Idle cycles (`in_vld` low) inside a frame do not change any output value.
- R10: The pixel with `in_eol` on row IMG_H-1 ends the frame, and the block then drains the rest of the frame without further input. A following frame that starts with `in_sof` after at least 3*(IMG_W+2) idle cycles is processed independently of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_gray | input | 8 | Filtered grayscale sample |
| in_r | input | 8 | Red sample of the same pixel |
| in_g | input | 8 | Green sample of the same pixel |
| in_b | input | 8 | Blue sample of the same pixel |
| out_vld | output | 1 | Output pixel valid |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a line |
| out_r | output | 8 | Red after overlay |
| out_g | output | 8 | Green after overlay |
| out_b | output | 8 | Blue after overlay |

## Verification
Several rules are checked on every cycle.
- The overlay must saturate red and blue and keep green on every edge pixel.
- Every non-edge pixel must pass through unchanged.
- The markers must appear only on valid pixels, with end-of-line falling on the last column.
- Each frame must hold exactly IMG_W*IMG_H pixels.

Other behaviour only shows up in the bench's scenarios. These are the Sobel orientation and the strict threshold (a step of 3 against a step of 4), replicate padding at the corners, the closing of the edge map, alignment of the RGB delay, independence from idle gaps, and a frame that follows after the minimum idle time.

// File: rtl/eco_pkg.sv
`timescale 1ns/1ps
package eco_pkg;

  typedef enum logic [1:0] {
    KIND_SOBEL  = 2'd0,
    KIND_DILATE = 2'd1,
    KIND_ERODE  = 2'd2
  } stage_kind_e;

  // |Gx|+|Gy| over a 3x3 window, tap index = row*3 + col
  function automatic logic [11:0] sobel_mag(input logic [8:0][7:0] w);
    int gx;
    int gy;
    gx = (int'(w[2]) + 2 * int'(w[5]) + int'(w[8]))
       - (int'(w[0]) + 2 * int'(w[3]) + int'(w[6]));
    gy = (int'(w[6]) + 2 * int'(w[7]) + int'(w[8]))
       - (int'(w[0]) + 2 * int'(w[1]) + int'(w[2]));
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    return 12'(gx + gy);
  endfunction

  function automatic logic [7:0] sat_add8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

endpackage

// File: rtl/eco_window_stage.sv
`timescale 1ns/1ps
module eco_window_stage
  import eco_pkg::*;
#(
  parameter int          IMG_W  = 16,
  parameter int          IMG_H  = 12,
  parameter int          IN_W   = 8,
  parameter int          SIDE_W = 24,
  parameter int          THR    = 12,
  parameter stage_kind_e KIND   = KIND_SOBEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_vld,
  input  logic              i_sof,
  input  logic              i_last,
  input  logic [IN_W-1:0]   i_pix,
  input  logic [SIDE_W-1:0] i_side,
  output logic              o_vld,
  output logic              o_sof,
  output logic              o_last,
  output logic              o_bit,
  output logic [SIDE_W-1:0] o_side
);

  localparam int DEPTH = 2 * IMG_W + 3;      // history: centre +/- (one line + one pixel)
  localparam int LAG   = IMG_W + 1;          // steps between a sample and its own output
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int CW    = $clog2(NPIX + IMG_W + 2);
  localparam int RW    = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int XW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic [IN_W-1:0]   hist [DEPTH];
  logic [SIDE_W-1:0] sdl  [LAG + 1];
  logic [CW-1:0]     tcnt;
  logic              flushing;
  logic              emit;
  logic [RW-1:0]     qrow, nrow;
  logic [XW-1:0]     qcol, ncol;

  // named internal events
  wire           take       = i_vld && !flushing;
  wire           step       = take || flushing;
  wire           restart    = take && i_sof;
  wire [CW-1:0]  tc_now     = restart ? '0 : tcnt;
  wire           will_emit  = step && (tc_now >= CW'(LAG));
  wire           next_final = (nrow == RW'(IMG_H - 1)) && (ncol == XW'(IMG_W - 1));

  always_ff @(posedge clk) begin
    if (step) begin
      hist[0] <= flushing ? '0 : i_pix;
      sdl[0]  <= flushing ? '0 : i_side;
      for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
      for (int k = 1; k <= LAG; k++)  sdl[k]  <= sdl[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt     <= '0;
      flushing <= 1'b0;
      emit     <= 1'b0;
      qrow     <= '0;
      qcol     <= '0;
      nrow     <= '0;
      ncol     <= '0;
    end else begin
      emit <= will_emit;
      if (step) tcnt <= tc_now + 1'b1;
      if (restart) begin
        nrow <= '0;
        ncol <= '0;
      end else if (will_emit) begin
        qrow <= nrow;
        qcol <= ncol;
        if (ncol == XW'(IMG_W - 1)) begin
          ncol <= '0;
          nrow <= nrow + 1'b1;
        end else begin
          ncol <= ncol + 1'b1;
        end
      end
      if (take && i_last)               flushing <= 1'b1;
      else if (will_emit && next_final) flushing <= 1'b0;
    end
  end

  // 3x3 window around (qrow,qcol) with replicate clamping
  logic [8:0][IN_W-1:0] win;
  always_comb begin
    for (int dr = 0; dr < 3; dr++) begin
      for (int dc = 0; dc < 3; dc++) begin
        int ro;
        int co;
        ro = dr - 1;
        co = dc - 1;
        if (ro < 0 && qrow == '0) ro = 0;
        if (ro > 0 && qrow == RW'(IMG_H - 1)) ro = 0;
        if (co < 0 && qcol == '0) co = 0;
        if (co > 0 && qcol == XW'(IMG_W - 1)) co = 0;
        win[dr*3 + dc] = hist[LAG - (ro * IMG_W + co)];
      end
    end
  end

  generate
    if (KIND == KIND_SOBEL) begin : g_sobel
      assign o_bit = sobel_mag(win) > 12'(THR);
    end else if (KIND == KIND_DILATE) begin : g_dilate
      assign o_bit = win[1][0] | win[3][0] | win[4][0] | win[5][0] | win[7][0];
    end else begin : g_erode
      assign o_bit = win[1][0] & win[3][0] & win[4][0] & win[5][0] & win[7][0];
    end
  endgenerate

  assign o_vld  = emit;
  assign o_sof  = emit && (qrow == '0) && (qcol == '0);
  assign o_last = emit && (qrow == RW'(IMG_H - 1)) && (qcol == XW'(IMG_W - 1));
  assign o_side = sdl[LAG];

endmodule

// File: rtl/edge_close_overlay.sv
`timescale 1ns/1ps
module edge_close_overlay
  import eco_pkg::*;
#(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 12,
  parameter int EDGE_THR = 12,
  parameter int EDGE_R   = 255,
  parameter int EDGE_G   = 0,
  parameter int EDGE_B   = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic       in_sof,
  input  logic       in_eol,
  input  logic [7:0] in_gray,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  output logic       out_vld,
  output logic       out_sof,
  output logic       out_eol,
  output logic [7:0] out_r,
  output logic [7:0] out_g,
  output logic [7:0] out_b
);

  localparam int RW = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int XW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  // input row tracking: the eol of the last row closes the frame
  logic [RW-1:0] in_row;
  wire  [RW-1:0] row_now = in_sof ? '0 : in_row;
  wire           in_last = in_vld && in_eol && (row_now == RW'(IMG_H - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  in_row <= '0;
    else if (in_vld && in_eol)   in_row <= in_last ? '0 : row_now + 1'b1;
    else if (in_vld && in_sof)   in_row <= '0;
  end

  logic        s1_vld, s1_sof, s1_last, s1_bit;
  logic        s2_vld, s2_sof, s2_last, s2_bit;
  logic        s3_vld, s3_sof, s3_last, s3_bit;
  logic [23:0] s1_side, s2_side, s3_side;

  eco_window_stage #(.IMG_W(IMG_W), .IMG_H(IMG_H), .IN_W(8), .SIDE_W(24),
                     .THR(EDGE_THR), .KIND(KIND_SOBEL)) u_sobel (
    .clk(clk), .rst_n(rst_n), .i_vld(in_vld), .i_sof(in_sof), .i_last(in_last),
    .i_pix(in_gray), .i_side({in_r, in_g, in_b}),
    .o_vld(s1_vld), .o_sof(s1_sof), .o_last(s1_last), .o_bit(s1_bit), .o_side(s1_side));

  eco_window_stage #(.IMG_W(IMG_W), .IMG_H(IMG_H), .IN_W(1), .SIDE_W(24),
                     .THR(EDGE_THR), .KIND(KIND_DILATE)) u_dilate (
    .clk(clk), .rst_n(rst_n), .i_vld(s1_vld), .i_sof(s1_sof), .i_last(s1_last),
    .i_pix(s1_bit), .i_side(s1_side),
    .o_vld(s2_vld), .o_sof(s2_sof), .o_last(s2_last), .o_bit(s2_bit), .o_side(s2_side));

  eco_window_stage #(.IMG_W(IMG_W), .IMG_H(IMG_H), .IN_W(1), .SIDE_W(24),
                     .THR(EDGE_THR), .KIND(KIND_ERODE)) u_erode (
    .clk(clk), .rst_n(rst_n), .i_vld(s2_vld), .i_sof(s2_sof), .i_last(s2_last),
    .i_pix(s2_bit), .i_side(s2_side),
    .o_vld(s3_vld), .o_sof(s3_sof), .o_last(s3_last), .o_bit(s3_bit), .o_side(s3_side));

  // overlay-side named wires
  wire       ov_vld  = s3_vld;
  wire       ov_sof  = s3_sof;
  wire       ov_edge = s3_bit;
  wire [7:0] ov_r    = s3_side[23:16];
  wire [7:0] ov_g    = s3_side[15:8];
  wire [7:0] ov_b    = s3_side[7:0];

  logic [XW-1:0] ov_colq;
  wire  [XW-1:0] ov_col = ov_sof ? '0 : ov_colq;
  wire           ov_eol = (ov_col == XW'(IMG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_colq <= '0;
      out_vld <= 1'b0;
      out_sof <= 1'b0;
      out_eol <= 1'b0;
      out_r   <= '0;
      out_g   <= '0;
      out_b   <= '0;
    end else begin
      out_vld <= ov_vld;
      out_sof <= ov_vld && ov_sof;
      out_eol <= ov_vld && ov_eol;
      if (ov_vld) begin
        ov_colq <= ov_eol ? '0 : ov_col + 1'b1;
        out_r   <= sat_add8(ov_r, ov_edge ? 8'(EDGE_R) : 8'd0);
        out_g   <= sat_add8(ov_g, ov_edge ? 8'(EDGE_G) : 8'd0);
        out_b   <= sat_add8(ov_b, ov_edge ? 8'(EDGE_B) : 8'd0);
      end
    end
  end

  wire unused_last = s3_last;

endmodule

// File: rtl/edge_close_overlay_chk.sv
`timescale 1ns/1ps
module edge_close_overlay_chk #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 12,
  parameter int EDGE_R = 255,
  parameter int EDGE_G = 0,
  parameter int EDGE_B = 255
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ov_vld,
  input logic       ov_edge,
  input logic [7:0] ov_r,
  input logic [7:0] ov_g,
  input logic [7:0] ov_b,
  input logic       out_vld,
  input logic       out_sof,
  input logic       out_eol,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b
);

  localparam int NPIX = IMG_W * IMG_H;

  int   col_q;
  int   pix_cnt;
  logic seen;
  int   cur_col;

  assign cur_col = out_sof ? 0 : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= 0;
      pix_cnt <= 0;
      seen    <= 1'b0;
    end else if (out_vld) begin
      col_q   <= (cur_col == IMG_W - 1) ? 0 : cur_col + 1;
      pix_cnt <= out_sof ? 1 : pix_cnt + 1;
      if (out_sof) seen <= 1'b1;
    end
  end

  // R6: edge pixels saturate red and blue, keep green
  assert_edge_paint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_vld && ov_edge |=> out_vld
      && (EDGE_R != 255 || out_r == 8'hFF)
      && (EDGE_B != 255 || out_b == 8'hFF)
      && (EDGE_G != 0   || out_g == $past(ov_g)));

  // R6: non-edge pixels pass through
  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_vld && !ov_edge |=> out_vld && out_r == $past(ov_r)
      && out_g == $past(ov_g) && out_b == $past(ov_b));

  // R8: markers only with valid
  assert_marks_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_vld);

  // R8: end-of-line exactly on the last column
  assert_eol_column_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && (seen || out_sof) |-> (out_eol == (cur_col == IMG_W - 1)));

  // R8: each completed frame has IMG_W*IMG_H pixels
  assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && out_sof && seen |-> pix_cnt == NPIX);

endmodule

bind edge_close_overlay edge_close_overlay_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .EDGE_R(EDGE_R), .EDGE_G(EDGE_G), .EDGE_B(EDGE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ov_vld(ov_vld), .ov_edge(ov_edge),
  .ov_r(ov_r), .ov_g(ov_g), .ov_b(ov_b),
  .out_vld(out_vld), .out_sof(out_sof), .out_eol(out_eol),
  .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/tb_edge_close_overlay.sv
`timescale 1ns/1ps
module tb_edge_close_overlay;

  localparam int W   = 16;
  localparam int H   = 12;
  localparam int GAP = 3 * (W + 2);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_gray = '0, in_r = '0, in_g = '0, in_b = '0;
  logic       out_vld, out_sof, out_eol;
  logic [7:0] out_r, out_g, out_b;

  always #4 clk = ~clk;  // 125 MHz

  edge_close_overlay #(.IMG_W(W), .IMG_H(H)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_eol(in_eol),
    .in_gray(in_gray), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_vld(out_vld), .out_sof(out_sof), .out_eol(out_eol),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  string tag = "R1";
  int unsigned seed = 32'h1234_5678;

  int gimg [H][W];
  int rimg [H][W];
  int gch  [H][W];
  int bimg [H][W];
  int em   [H][W];
  int dm   [H][W];
  logic [25:0] expq [$];

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int clampi(int v, int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic int gp(int y, int x);
    return gimg[clampi(y, H-1)][clampi(x, W-1)];
  endfunction

  function automatic int ep(int y, int x);
    return em[clampi(y, H-1)][clampi(x, W-1)];
  endfunction

  function automatic int dp(int y, int x);
    return dm[clampi(y, H-1)][clampi(x, W-1)];
  endfunction

  // behavioural model: R2 R3 R4 R5 R6 R7 R8
  task automatic build_expect();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int gx, gy;
        gx = gp(y-1,x+1) + 2*gp(y,x+1) + gp(y+1,x+1) - gp(y-1,x-1) - 2*gp(y,x-1) - gp(y+1,x-1);
        gy = gp(y+1,x-1) + 2*gp(y+1,x) + gp(y+1,x+1) - gp(y-1,x-1) - 2*gp(y-1,x) - gp(y-1,x+1);
        em[y][x] = ((gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy)) > 12 ? 1 : 0;
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        dm[y][x] = ep(y,x) | ep(y-1,x) | ep(y+1,x) | ep(y,x-1) | ep(y,x+1);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int c, er, eg, eb;
        c  = dp(y,x) & dp(y-1,x) & dp(y+1,x) & dp(y,x-1) & dp(y,x+1);
        er = c ? 255 : rimg[y][x];
        eg = gch[y][x];
        eb = c ? 255 : bimg[y][x];
        expq.push_back({(y == 0 && x == 0), (x == W-1), 8'(er), 8'(eg), 8'(eb)});
      end
  endtask

  task automatic fill(input int pat);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        rimg[y][x] = (x * 16 + y) & 255;
        gch[y][x]  = (y * 20 + x) & 255;
        bimg[y][x] = (y * W + x) & 255;
        case (pat)
          0: gimg[y][x] = 100;
          1: gimg[y][x] = (x < 8) ? 50 : 53;
          2: gimg[y][x] = (x < 8) ? 50 : 54;
          3: gimg[y][x] = (y < 3 && x < 3) ? 220 : 20;
          4: gimg[y][x] = ((rnd() % 5) == 0) ? 180 : 40;
          default: gimg[y][x] = int'(rnd() & 255);
        endcase
      end
  endtask

  task automatic send_frame(input bit gaps);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (gaps) begin
          while ((rnd() % 3) == 0) begin
            in_vld = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            @(negedge clk);
          end
        end
        in_vld  = 1'b1;
        in_sof  = (y == 0 && x == 0);
        in_eol  = (x == W-1);
        in_gray = 8'(gimg[y][x]);
        in_r    = 8'(rimg[y][x]);
        in_g    = 8'(gch[y][x]);
        in_b    = 8'(bimg[y][x]);
        @(negedge clk);
      end
    in_vld = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (expq.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    n_vec++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R8/R10 %s: %0d pixels missing, expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  task automatic run_frame(input string t, input int pat, input bit gaps);
    tag = t;
    fill(pat);
    build_expect();
    send_frame(gaps);
    idle(GAP);
    drain();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!out_vld && (out_sof || out_eol)) begin
        n_bad++;
        $display("FAIL R8: marker without valid sof=%0b eol=%0b, expected 0", out_sof, out_eol);
      end
      if (out_vld) begin
        logic [25:0] got, e;
        got = {out_sof, out_eol, out_r, out_g, out_b};
        n_vec++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R8 %s: unexpected pixel %h, expected none", tag, got);
        end else begin
          e = expq.pop_front();
          if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got sof/eol/rgb %h, expected %h", tag, got, e);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: %0d cycles, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    n_vec++;
    if (out_vld !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: vld/sof/eol %b%b%b during reset, expected 000", out_vld, out_sof, out_eol);
    end
    rst_n = 1'b1;
    idle(4);
    n_vec++;
    if (out_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_vld %b after reset, expected 0", out_vld);
    end

    run_frame("R7", 0, 1'b0);   // flat gray: RGB aligned, unchanged (R6 pass-through)
    run_frame("R3", 1, 1'b0);   // step of 3: magnitude 12, no edge
    run_frame("R2", 2, 1'b0);   // step of 4: magnitude 16, edges painted (R6)
    run_frame("R4", 3, 1'b0);   // bright corner block: replicate padding
    run_frame("R5", 4, 1'b0);   // sparse bright dots: closing fills gaps
    run_frame("R9", 5, 1'b1);   // random image with idle gaps

    // R10: frame end by last eol, next frame after the minimum idle gap
    tag = "R10";
    fill(5);
    build_expect();
    send_frame(1'b0);
    idle(GAP);
    fill(4);
    build_expect();
    send_frame(1'b0);
    idle(GAP);
    drain();

    idle(10);
    finish_run();
  end

endmodule